// File: doc/BRIEF.md
# NAND Page-Program Command Interface

This block is the device side of a NAND flash command port, limited to programming pages. A host drives an 8-bit bus. Each bus cycle is qualified by a write strobe and is tagged as a command (`cmdLatch`) or an address (`addrLatch`). When neither latch is set, the cycle is data. A program sequence has four parts: a setup command, five address cycles (two column bytes, then three row bytes), the data bytes, and a confirm command. While data is loading, the host may move the load column with a random-input command followed by two column bytes. It may do this any number of times.

On confirm, the block enters an internal program phase that lasts a fixed number of clocks. During that phase the ready/busy output is low and only read-status and reset commands take effect. Programming can only clear cells (each cell becomes old AND new). Each page has its own counter of partial programs. A page that has already used its allowance is refused until a block erase clears the counters of its block. A small behavioural array holds the cells, and a combinational peek port exposes them.

The page size must be a power of two. The page count and the pages per block must also be powers of two, with at most 256 pages in total.

Top module: `nand_pgm_if`

## Requirements
- R1: After reset, `readyBusy` is 1, `statusMode` is 0 and `statusOut` is 8'hC0. In the status byte, bit 7 is the constant not-protected flag, bit 6 is ready and bit 0 is fail. Every cell reads 8'hFF.
- R2: Command 8'h80 starts a program. It sets the page register to all ones. Five address cycles follow in this order: column low, column high, page index, and two ignored row bytes. Data cycles then fill the page register at consecutive columns, starting from the given column.
- R3: Command 8'h85 in the load phase, followed by two column address cycles (low byte first), moves the load point. Loading continues from the new column. This can repeat within one page.
- R4: Confirm (8'h10) issued with no data cycle after the address starts nothing. `readyBusy` stays 1 and the array is unchanged.
- R5: From the confirm cycle, `readyBusy` and status bit 6 stay 0 for exactly `PROG_CYCLES` clocks, then return to 1.
- R6: While busy, any command other than 8'h70 and 8'hFF has no effect, and data and address cycles have no effect either. The program ends on time with the loaded data, and the interface stays in read-status mode.
- R7: From confirm onward, `statusMode` is 1. It stays 1 after completion and through 8'h70, and it drops only on 8'h80, 8'h60 or 8'hFF.
- R8: A completed program leaves each cell of the page equal to its old value AND the page register. A 1 written over a 0 leaves the 0 and does not set the fail bit.
- R9: A page that has had `MAX_PARTIAL` programs refuses the next one. The refused program still goes busy for `PROG_CYCLES` clocks, then sets status bit 0 (status 8'hC1) and leaves the array unchanged. Other pages are unaffected, and the next accepted program clears bit 0.
- R10: The sequence 8'h60, three row address cycles (page index first) and 8'hD0 clears the partial-program counters of every page in that page's block. It changes no cell.
- R11: Command 8'hFF, in any state, aborts the current operation. No cell changes. `readyBusy` is 0 for exactly `RST_CYCLES` clocks. Bit 0 and `statusMode` are cleared.
- R12: Data cycles with a column at or beyond `PAGE_BYTES` are dropped. They do not wrap onto the start of the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdLatch | input | 1 | Marks the bus cycle as a command |
| addrLatch | input | 1 | Marks the bus cycle as an address |
| wrStrobe | input | 1 | One-clock qualifier for a bus cycle |
| ioIn | input | 8 | Bus byte |
| peekPage | input | $clog2(PAGES) | Page index for the array peek |
| peekCol | input | $clog2(PAGE_BYTES) | Column for the array peek |
| readyBusy | output | 1 | 1 = ready, 0 = program or reset in progress |
| statusOut | output | 8 | Status byte {1, ready, 00000, fail} |
| statusMode | output | 1 | Interface is in read-status mode |
| peekData | output | 8 | Cell contents at the peek address |

## Verification
The assertions assume well-formed bus cycles. `cmdLatch` and `addrLatch` are never both high with `wrStrobe`. An address cycle never directly follows an erase confirm, so the page index still names the erased block on the next clock. The bench meets these assumptions by driving every bus cycle through one task. That task raises exactly one latch (or none, for data) for one clock, and clears all qualifiers on the next falling edge. Busy-time checks count clocks from the confirm or reset cycle itself, including any bus cycles issued while busy.

// File: rtl/nand_pgm_pkg.sv
package nand_pgm_pkg;

  localparam logic [7:0] CMD_SETUP   = 8'h80;
  localparam logic [7:0] CMD_RANDCOL = 8'h85;
  localparam logic [7:0] CMD_CONFIRM = 8'h10;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_RESET   = 8'hFF;
  localparam logic [7:0] CMD_ERASE1  = 8'h60;
  localparam logic [7:0] CMD_ERASE2  = 8'hD0;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_LOAD, S_RCOL, S_EADDR, S_ECONF, S_BUSY, S_RSTW
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       clrPage;
    logic       ldAddr;
    logic [2:0] addrIdx;   // 0/1 column bytes, 2..4 row bytes
    logic       wrData;
    logic       commit;
    logic       clrCounts;
  } dpStrobe_t;

endpackage

// File: rtl/nand_pgm_ctrl.sv
module nand_pgm_ctrl
  import nand_pgm_pkg::*;
#(
  parameter int PROG_CYCLES = 20,
  parameter int RST_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdLatch,
  input  logic       addrLatch,
  input  logic       wrStrobe,
  input  logic [7:0] ioIn,
  input  logic       limitHit,
  output dpStrobe_t  strb,
  output logic       readyBusy,
  output logic [7:0] statusOut,
  output logic       statusMode
);

  localparam int WAIT_MAX = (PROG_CYCLES > RST_CYCLES) ? PROG_CYCLES : RST_CYCLES;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  ctrlState_t        state;
  logic [2:0]        addrCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic              gotData;
  logic              refused;
  logic              failFlag;

  logic isCmd, isAddr, isData, abortCmd;

  assign isCmd    = wrStrobe && cmdLatch && !addrLatch;
  assign isAddr   = wrStrobe && addrLatch && !cmdLatch;
  assign isData   = wrStrobe && !cmdLatch && !addrLatch;
  assign abortCmd = isCmd && (ioIn == CMD_RESET);

  always_comb begin
    strb = '0;
    case (state)
      S_IDLE:  strb.clrPage = isCmd && (ioIn == CMD_SETUP);
      S_ADDR: begin
        strb.ldAddr  = isAddr;
        strb.addrIdx = addrCnt;
      end
      S_LOAD:  strb.wrData = isData;
      S_RCOL: begin
        strb.ldAddr  = isAddr;
        strb.addrIdx = addrCnt;
      end
      S_EADDR: begin
        strb.ldAddr  = isAddr;
        strb.addrIdx = addrCnt + 3'd2;
      end
      S_ECONF: strb.clrCounts = isCmd && (ioIn == CMD_ERASE2);
      S_BUSY:  strb.commit = (waitCnt == '0) && !refused && !abortCmd;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      addrCnt    <= '0;
      waitCnt    <= '0;
      gotData    <= 1'b0;
      refused    <= 1'b0;
      failFlag   <= 1'b0;
      statusMode <= 1'b0;
    end else if (abortCmd) begin
      state      <= S_RSTW;
      waitCnt    <= WAIT_W'(RST_CYCLES - 1);
      failFlag   <= 1'b0;
      statusMode <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (isCmd) begin
          if (ioIn == CMD_SETUP) begin
            state      <= S_ADDR;
            addrCnt    <= '0;
            gotData    <= 1'b0;
            statusMode <= 1'b0;
          end else if (ioIn == CMD_ERASE1) begin
            state      <= S_EADDR;
            addrCnt    <= '0;
            statusMode <= 1'b0;
          end else if (ioIn == CMD_STATUS) begin
            statusMode <= 1'b1;
          end
        end
        S_ADDR: if (isAddr) begin
          if (addrCnt == 3'd4) state <= S_LOAD;
          else addrCnt <= addrCnt + 3'd1;
        end
        S_LOAD: begin
          if (isData) gotData <= 1'b1;
          if (isCmd && ioIn == CMD_RANDCOL) begin
            state   <= S_RCOL;
            addrCnt <= '0;
          end else if (isCmd && ioIn == CMD_CONFIRM) begin
            if (gotData) begin
              state      <= S_BUSY;
              waitCnt    <= WAIT_W'(PROG_CYCLES - 1);
              refused    <= limitHit;
              failFlag   <= 1'b0;
              statusMode <= 1'b1;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_RCOL: if (isAddr) begin
          if (addrCnt == 3'd1) state <= S_LOAD;
          else addrCnt <= addrCnt + 3'd1;
        end
        S_EADDR: if (isAddr) begin
          if (addrCnt == 3'd2) state <= S_ECONF;
          else addrCnt <= addrCnt + 3'd1;
        end
        S_ECONF: if (isCmd) state <= S_IDLE;
        S_BUSY: begin
          if (isCmd && ioIn == CMD_STATUS) statusMode <= 1'b1;
          if (waitCnt == '0) begin
            state    <= S_IDLE;
            failFlag <= refused;
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        S_RSTW: begin
          if (waitCnt == '0) state <= S_IDLE;
          else waitCnt <= waitCnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign readyBusy = (state != S_BUSY) && (state != S_RSTW);
  assign statusOut = {1'b1, readyBusy, 5'b0, failFlag};

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clrPage, strb.ldAddr, strb.wrData, strb.commit, strb.clrCounts})); // R2
  AST_NO_EMPTY_CONFIRM: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LOAD && !gotData && isCmd && ioIn == CMD_CONFIRM) |=> readyBusy); // R4
  AST_BUSY_FILTER: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY && waitCnt != '0 && !abortCmd) |=> !readyBusy); // R6
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY && waitCnt == '0 && !abortCmd) |=> (readyBusy && statusMode)); // R7
  AST_REFUSE_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY && waitCnt == '0 && refused && !abortCmd) |=> statusOut[0]); // R9
  AST_ABORT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    abortCmd |-> !strb.commit); // R11

endmodule

// File: rtl/nand_pgm_dpath.sv
module nand_pgm_dpath
  import nand_pgm_pkg::*;
#(
  parameter int PAGE_BYTES    = 64,
  parameter int PAGES         = 8,
  parameter int PAGES_PER_BLK = 4,
  parameter int MAX_PARTIAL   = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [7:0]                    ioIn,
  input  dpStrobe_t                     strb,
  input  logic [$clog2(PAGES)-1:0]      peekPage,
  input  logic [$clog2(PAGE_BYTES)-1:0] peekCol,
  output logic                          limitHit,
  output logic [7:0]                    peekData
);

  localparam int COL_W     = $clog2(PAGE_BYTES);
  localparam int PAGE_W    = $clog2(PAGES);
  localparam int BLK_SHIFT = $clog2(PAGES_PER_BLK);
  localparam int CNT_W     = $clog2(MAX_PARTIAL + 1);
  localparam int MEM_DEPTH = PAGES * PAGE_BYTES;
  localparam logic [16:0] PAGE_LIM = 17'(PAGE_BYTES);

  logic [7:0]        pageReg [PAGE_BYTES];
  logic [7:0]        cells   [MEM_DEPTH];
  logic [CNT_W-1:0]  partCnt [PAGES];
  logic [15:0]       colPtr;
  logic [PAGE_W-1:0] pageSel;
  logic              colInPage;

  assign colInPage = {1'b0, colPtr} < PAGE_LIM;
  assign limitHit  = partCnt[pageSel] >= CNT_W'(MAX_PARTIAL);
  assign peekData  = cells[{peekPage, peekCol}];

  // page register, column pointer and row latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAGE_BYTES; i++) pageReg[i] <= 8'hFF;
      colPtr  <= '0;
      pageSel <= '0;
    end else begin
      if (strb.clrPage)
        for (int i = 0; i < PAGE_BYTES; i++) pageReg[i] <= 8'hFF;
      if (strb.ldAddr) begin
        case (strb.addrIdx)
          3'd0:    colPtr[7:0]  <= ioIn;
          3'd1:    colPtr[15:8] <= ioIn;
          3'd2:    pageSel      <= ioIn[PAGE_W-1:0];
          default: ;
        endcase
      end
      if (strb.wrData) begin
        if (colInPage) pageReg[colPtr[COL_W-1:0]] <= ioIn;
        if (colPtr != 16'hFFFF) colPtr <= colPtr + 16'd1;
      end
    end
  end

  // cell array: program only clears bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) cells[i] <= 8'hFF;
    end else if (strb.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        cells[{pageSel, COL_W'(i)}] <= cells[{pageSel, COL_W'(i)}] & pageReg[i];
    end
  end

  // partial-program counters per page
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < PAGES; p++) partCnt[p] <= '0;
    end else if (strb.commit) begin
      partCnt[pageSel] <= partCnt[pageSel] + 1'b1;
    end else if (strb.clrCounts) begin
      for (int p = 0; p < PAGES; p++)
        if ((PAGE_W'(p) >> BLK_SHIFT) == (pageSel >> BLK_SHIFT)) partCnt[p] <= '0;
    end
  end

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (partCnt[pageSel] < CNT_W'(MAX_PARTIAL))); // R9
  AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCounts |=> !limitHit); // R10

endmodule

// File: rtl/nand_pgm_if.sv
module nand_pgm_if
  import nand_pgm_pkg::*;
#(
  parameter int PAGE_BYTES    = 64,
  parameter int PAGES         = 8,
  parameter int PAGES_PER_BLK = 4,
  parameter int MAX_PARTIAL   = 4,
  parameter int PROG_CYCLES   = 20,
  parameter int RST_CYCLES    = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdLatch,
  input  logic                          addrLatch,
  input  logic                          wrStrobe,
  input  logic [7:0]                    ioIn,
  input  logic [$clog2(PAGES)-1:0]      peekPage,
  input  logic [$clog2(PAGE_BYTES)-1:0] peekCol,
  output logic                          readyBusy,
  output logic [7:0]                    statusOut,
  output logic                          statusMode,
  output logic [7:0]                    peekData
);

  dpStrobe_t strb;
  logic      limitHit;

  nand_pgm_ctrl #(
    .PROG_CYCLES(PROG_CYCLES),
    .RST_CYCLES (RST_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdLatch  (cmdLatch),
    .addrLatch (addrLatch),
    .wrStrobe  (wrStrobe),
    .ioIn      (ioIn),
    .limitHit  (limitHit),
    .strb      (strb),
    .readyBusy (readyBusy),
    .statusOut (statusOut),
    .statusMode(statusMode)
  );

  nand_pgm_dpath #(
    .PAGE_BYTES   (PAGE_BYTES),
    .PAGES        (PAGES),
    .PAGES_PER_BLK(PAGES_PER_BLK),
    .MAX_PARTIAL  (MAX_PARTIAL)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ioIn    (ioIn),
    .strb    (strb),
    .peekPage(peekPage),
    .peekCol (peekCol),
    .limitHit(limitHit),
    .peekData(peekData)
  );

endmodule

// File: tb/nand_pgm_if_tb.sv
module nand_pgm_if_tb;

  localparam int PB   = 64;
  localparam int NP   = 8;
  localparam int PROG = 20;
  localparam int RSTC = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdLatch = 1'b0, addrLatch = 1'b0, wrStrobe = 1'b0;
  logic [7:0] ioIn = 8'h00;
  logic [2:0] peekPage = '0;
  logic [5:0] peekCol = '0;
  logic       readyBusy, statusMode;
  logic [7:0] statusOut, peekData;

  int testCount = 0;
  int failCount = 0;
  logic done = 1'b0;

  logic [7:0] sh   [NP*PB];
  logic [7:0] pend [PB];

  always #2 clk = ~clk;

  nand_pgm_if u_dut (
    .clk(clk), .rstN(rstN), .cmdLatch(cmdLatch), .addrLatch(addrLatch),
    .wrStrobe(wrStrobe), .ioIn(ioIn), .peekPage(peekPage), .peekCol(peekCol),
    .readyBusy(readyBusy), .statusOut(statusOut), .statusMode(statusMode),
    .peekData(peekData)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busOp(input logic c, input logic a, input logic [7:0] v);
    cmdLatch = c; addrLatch = a; ioIn = v; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0; cmdLatch = 1'b0; addrLatch = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] v);  busOp(1'b1, 1'b0, v); endtask
  task automatic addr(input logic [7:0] v); busOp(1'b0, 1'b1, v); endtask
  task automatic dat(input logic [7:0] v);  busOp(1'b0, 1'b0, v); endtask

  task automatic setup(input int page, input int col);
    for (int i = 0; i < PB; i++) pend[i] = 8'hFF;
    cmd(8'h80);
    addr(col[7:0]); addr(col[15:8]); addr(page[7:0]); addr(8'h00); addr(8'h00);
  endtask

  task automatic load(input int col, input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = seed ^ 8'(k * 29);
      dat(d);
      if (col + k < PB) pend[col + k] = d;
    end
  endtask

  task automatic randCol(input int col);
    cmd(8'h85); addr(col[7:0]); addr(col[15:8]);
  endtask

  task automatic applyPend(input int page);
    for (int i = 0; i < PB; i++) sh[page*PB + i] = sh[page*PB + i] & pend[i];
  endtask

  task automatic waitReady(input int start, output int n);
    n = start;
    while (!readyBusy && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic checkPage(input int page, input string req);
    int bad = 0, firstAct = 0, firstExp = 0;
    for (int i = 0; i < PB; i++) begin
      peekPage = 3'(page); peekCol = 6'(i);
      #0.1;
      if (peekData !== sh[page*PB + i]) begin
        if (bad == 0) begin firstAct = peekData; firstExp = sh[page*PB + i]; end
        bad++;
      end
    end
    check(bad == 0, req, firstAct, firstExp);
  endtask

  // confirm and time the busy phase; expect given final status
  task automatic confirmAndWait(input int page, input logic [7:0] expStat,
                                input logic apply, input string req);
    int n;
    cmd(8'h10);
    check(!readyBusy && !statusOut[6], {req, " busy after confirm"}, statusOut, 8'h80);
    waitReady(0, n);
    check(n == PROG, {req, " busy length"}, n, PROG);
    check(statusOut == expStat, {req, " final status"}, statusOut, expStat);
    if (apply) applyPend(page);
    checkPage(page, req);
  endtask

  task automatic t_reset();
    check(readyBusy && statusOut == 8'hC0 && !statusMode, "R1 reset status", statusOut, 8'hC0);
    checkPage(3, "R1 erased cells");
  endtask

  task automatic t_basic();
    setup(1, 4); load(4, 8, 8'h5A);
    confirmAndWait(1, 8'hC0, 1'b1, "R2 R5 basic");
    check(statusMode, "R7 status mode after program", statusMode, 1);
  endtask

  task automatic t_random();
    setup(2, 0); load(0, 3, 8'h11);
    randCol(20); load(20, 3, 8'h22);
    randCol(40); load(40, 2, 8'h33);
    confirmAndWait(2, 8'hC0, 1'b1, "R3 random column");
  endtask

  task automatic t_noData();
    setup(3, 0);
    cmd(8'h10);
    check(readyBusy, "R4 empty confirm ready", readyBusy, 1);
    @(negedge clk);
    check(readyBusy, "R4 empty confirm stays ready", readyBusy, 1);
    checkPage(3, "R4 array untouched");
  endtask

  task automatic t_busyFilter();
    int n;
    setup(4, 8); load(8, 6, 8'hC3);
    cmd(8'h10);
    cmd(8'h80); cmd(8'h60); dat(8'h00); addr(8'h00);
    waitReady(4, n);
    check(n == PROG, "R6 busy length with ignored cycles", n, PROG);
    check(statusMode, "R6 still read-status mode", statusMode, 1);
    applyPend(4);
    checkPage(4, "R6 loaded data programmed");
  endtask

  task automatic t_statusMode();
    int n;
    cmd(8'h70);
    check(statusMode, "R7 70h keeps status mode", statusMode, 1);
    cmd(8'h80);
    check(!statusMode, "R7 80h leaves status mode", statusMode, 0);
    cmd(8'hFF);
    waitReady(0, n);
    check(n == RSTC, "R11 reset from address phase", n, RSTC);
  endtask

  task automatic t_overwrite();
    setup(1, 4); load(4, 8, 8'hF0);
    confirmAndWait(1, 8'hC0, 1'b1, "R8 AND programming");
  endtask

  task automatic t_limit();
    for (int r = 0; r < 4; r++) begin
      setup(5, r * 4); load(r * 4, 2, 8'(8'h40 + r));
      confirmAndWait(5, 8'hC0, 1'b1, "R9 allowed partial");
    end
    setup(5, 30); load(30, 4, 8'h00);
    confirmAndWait(5, 8'hC1, 1'b0, "R9 refused over limit");
    setup(6, 0); load(0, 4, 8'h77);
    confirmAndWait(6, 8'hC0, 1'b1, "R9 other page accepted");
  endtask

  task automatic t_erase();
    cmd(8'h60); addr(8'h05); addr(8'h00); addr(8'h00); cmd(8'hD0);
    check(!statusMode && readyBusy, "R10 erase state", statusMode, 0);
    checkPage(5, "R10 erase leaves cells");
    setup(5, 30); load(30, 4, 8'h0F);
    confirmAndWait(5, 8'hC0, 1'b1, "R10 program after erase");
  endtask

  task automatic t_abort();
    int n;
    setup(0, 0); load(0, 16, 8'h01);
    cmd(8'h10);
    repeat (5) @(negedge clk);
    cmd(8'hFF);
    waitReady(0, n);
    check(n == RSTC, "R11 abort ready delay", n, RSTC);
    check(statusOut == 8'hC0 && !statusMode, "R11 status after abort", statusOut, 8'hC0);
    checkPage(0, "R11 abort leaves cells");
  endtask

  task automatic t_overflow();
    setup(7, 60); load(60, 8, 8'h99);
    confirmAndWait(7, 8'hC0, 1'b1, "R12 past-end bytes dropped");
  endtask

  initial begin
    for (int i = 0; i < NP*PB; i++) sh[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_random();
    t_noData();
    t_busyFilter();
    t_statusMode();
    t_overwrite();
    t_limit();
    t_erase();
    t_abort();
    t_overflow();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule